// File: doc/BRIEF.md
# Lockable Clock-Routing Configuration Register File

This block stores the clock-routing setup for a set of peripheral clock channels. Each channel has three fields: the clock generator it takes its clock from, an enable, and a write lock. Software does not see one register per channel. It reaches every channel through one 16-bit control word. A write goes to the channel named in the word's channel field. A read returns the channel that was named by the most recent write.

The routing outputs go to the clock multiplexers. The per-generator lock vector goes to the generator block, which uses it to freeze a generator's source and divider. A lock can only be set. Once set, it holds until a power-on reset. When a channel is locked, the generator it selects is locked as well, except generator 0, which can never be locked.

There are two reset inputs. A user reset leaves locked channels unchanged and has its own rules for the real-time-clock channel and the watchdog channel. Nonvolatile configuration inputs supply the watchdog channel's enable and lock when a reset reloads that channel.

Top module: `clkroute_regfile`

## Requirements
- R1: Control word fields are: bit 15 = lock, bit 14 = enable, bits 11:8 = generator, bits 5:0 = channel. On a read, all other bits are zero. `rdata` shows the channel named by the last write, one cycle after `rd_en` is high. It holds its value in every cycle where `rd_en` is low.
- R2: Power-on reset clears every channel to generator 0, disabled, unlocked. The exception is channel 1 (watchdog): it takes generator 2, enable = `nv_wdt_en`, lock = `nv_wdt_lock`. Power-on reset clears `gen_lock`, except that bit 2 is set when `nv_wdt_lock` is 1. It also clears the read pointer and `rdata`.
- R3: A write whose channel is 28 or higher, or whose generator is 8 or higher, changes no channel. The read pointer still takes the written channel. A read of a reserved channel returns only that channel number.
- R4: A write with lock = 1 locks the channel and sets `gen_lock` for the generator it selects. `gen_lock[0]` is never set.
- R5: A write to a locked channel has no effect.
- R6: A write to a channel whose currently selected generator is locked has no effect.
- R7: Channel locks and `gen_lock` bits are cleared only by power-on reset. User reset leaves them as they are.
- R8: User reset returns every unlocked channel other than channels 1 and 2 to generator 0 and disabled. A locked channel keeps its value.
- R9: On user reset, channel 2 (real-time clock) is cleared only when it is both unlocked and disabled. Otherwise it keeps its value.
- R10: On user reset, an unlocked channel 1 reloads generator 2, with enable = `nv_wdt_en`. A locked channel 1 does not change.
- R11: `gen_sel[3*i +: 3]` and `clk_en[i]` always show channel i's stored generator and enable.
- R12: Power-on reset takes priority over user reset, and user reset takes priority over writes. A write in a cycle where a user reset is applied is lost. User reset also clears the read pointer and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| usr_rst | input | 1 | Synchronous user reset, active high |
| nv_wdt_en | input | 1 | Nonvolatile watchdog clock enable |
| nv_wdt_lock | input | 1 | Nonvolatile watchdog always-on (lock) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Control word to write |
| rdata | output | 16 | Read control word, valid one cycle after `rd_en` |
| gen_sel | output | 84 | Generator select per channel, 3 bits each |
| clk_en | output | 28 | Clock enable per channel |
| gen_lock | output | 8 | Lock flag per generator |

## Verification
A wrong lock bit in a channel does not show on the routing outputs at once. It shows the first time a later write to that channel is accepted or dropped, or when a user reset clears or keeps that channel. The bench therefore compares every routing output, the lock vector and the read word against a behavioural model after every clock edge. It also uses write-then-rewrite sequences and user resets to expose hidden lock state within one or two cycles. A stale read pointer shows on `rdata` in the cycle after the next read strobe.

// File: rtl/clkroute_pkg.sv
package clkroute_pkg;

    localparam int WORD_W      = 16;
    localparam int CH_W        = 6;
    localparam int GEN_FIELD_W = 4;
    localparam int GEN_W       = 3;
    localparam int CH_COUNT    = 28;
    localparam int GEN_COUNT   = 8;
    localparam int WDT_CH      = 1;
    localparam int RTC_CH      = 2;
    localparam int WDT_GEN     = 2;

    typedef enum logic [1:0] {
        CH_PLAIN = 2'd0,
        CH_RTC   = 2'd1,
        CH_WDT   = 2'd2
    } ch_kind_e;

    typedef struct packed {
        logic             lock;
        logic             en;
        logic [GEN_W-1:0] gen;
    } route_t;

    typedef struct packed {
        logic                   lock;
        logic                   en;
        logic [1:0]             pad_hi;
        logic [GEN_FIELD_W-1:0] gen;
        logic [1:0]             pad_lo;
        logic [CH_W-1:0]        ch;
    } ctrl_word_t;

    function automatic ch_kind_e kind_of(input int ch);
        if (ch == WDT_CH) return CH_WDT;
        if (ch == RTC_CH) return CH_RTC;
        return CH_PLAIN;
    endfunction

    function automatic ctrl_word_t to_ctrl(input logic [WORD_W-1:0] w);
        return ctrl_word_t'(w);
    endfunction

    function automatic logic [WORD_W-1:0] from_route(input route_t r,
                                                     input logic [CH_W-1:0] ch,
                                                     input logic valid);
        ctrl_word_t cw;
        cw        = '0;
        cw.ch     = ch;
        if (valid) begin
            cw.lock = r.lock;
            cw.en   = r.en;
            cw.gen  = {1'b0, r.gen};
        end
        return cw;
    endfunction

endpackage

// File: rtl/clkroute_wdec.sv
module clkroute_wdec
    import clkroute_pkg::*;
#(
    parameter int NUM_CH   = CH_COUNT,
    parameter int NUM_GENS = GEN_COUNT
) (
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wdata,
    input  route_t              tgt,
    input  logic [NUM_GENS-1:0] gen_lock,
    output logic                wr_ok,
    output logic [NUM_CH-1:0]   wr_sel,
    output route_t              wr_route,
    output logic [NUM_GENS-1:0] lock_set
);
    localparam logic [CH_W-1:0]        CH_LIMIT  = CH_W'(NUM_CH);
    localparam logic [GEN_FIELD_W-1:0] GEN_LIMIT = GEN_FIELD_W'(NUM_GENS);

    ctrl_word_t cw;
    logic       ch_ok;
    logic       gen_ok;
    logic       tgt_frozen;

    always_comb begin
        cw         = to_ctrl(wdata);
        ch_ok      = cw.ch < CH_LIMIT;
        gen_ok     = cw.gen < GEN_LIMIT;
        tgt_frozen = tgt.lock | gen_lock[tgt.gen];
        wr_ok      = wr_en & ch_ok & gen_ok & ~tgt_frozen;
        wr_route.lock = cw.lock;
        wr_route.en   = cw.en;
        wr_route.gen  = cw.gen[GEN_W-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_sel[i] = wr_ok & (cw.ch == CH_W'(i));
    end

    for (genvar g = 0; g < NUM_GENS; g++) begin : g_lset
        if (g == 0) begin : g_zero
            assign lock_set[g] = 1'b0;
        end else begin : g_other
            assign lock_set[g] = wr_ok & cw.lock & (cw.gen == GEN_FIELD_W'(g));
        end
    end

endmodule

// File: rtl/clkroute_entry.sv
module clkroute_entry
    import clkroute_pkg::*;
#(
    parameter ch_kind_e KIND = CH_PLAIN
) (
    input  logic   clk,
    input  logic   por_rst,
    input  logic   usr_rst,
    input  logic   nv_en,
    input  logic   nv_lock,
    input  logic   wr_sel,
    input  route_t wr_route,
    output route_t route_q
);
    localparam logic [GEN_W-1:0] WDT_GEN_V = GEN_W'(WDT_GEN);

    route_t por_val;
    route_t usr_val;

    always_comb begin
        por_val = '0;
        usr_val = route_q;
        case (KIND)
            CH_WDT: begin
                por_val = '{lock: nv_lock, en: nv_en, gen: WDT_GEN_V};
                if (!route_q.lock) usr_val = '{lock: 1'b0, en: nv_en, gen: WDT_GEN_V};
            end
            CH_RTC: begin
                if (!route_q.lock && !route_q.en) usr_val = '0;
            end
            default: begin
                if (!route_q.lock) usr_val = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (por_rst)      route_q <= por_val;
        else if (usr_rst) route_q <= usr_val;
        else if (wr_sel)  route_q <= wr_route;
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (por_rst)
        route_q.lock |=> route_q.lock);

    assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (por_rst)
        route_q.lock |=> $stable(route_q));

    if (KIND == CH_RTC) begin : g_rtc_chk
        assert_rtc_keep_R9: assert property (@(posedge clk) disable iff (por_rst)
            (usr_rst && route_q.en) |=> $stable(route_q));
    end else if (KIND == CH_WDT) begin : g_wdt_chk
        assert_wdt_reload_R10: assert property (@(posedge clk) disable iff (por_rst)
            (usr_rst && !route_q.lock) |=>
            (route_q.gen == WDT_GEN_V && route_q.en == $past(nv_en) && !route_q.lock));
    end else begin : g_plain_chk
        assert_plain_clear_R8: assert property (@(posedge clk) disable iff (por_rst)
            (usr_rst && !route_q.lock) |=> (route_q == '0));
    end

endmodule

// File: rtl/clkroute_glock.sv
module clkroute_glock
    import clkroute_pkg::*;
#(
    parameter int NUM_GENS = GEN_COUNT
) (
    input  logic                clk,
    input  logic                por_rst,
    input  logic                nv_lock,
    input  logic [NUM_GENS-1:0] lock_set,
    output logic [NUM_GENS-1:0] gen_lock
);
    logic [NUM_GENS-1:0] por_val;

    always_comb begin
        por_val          = '0;
        por_val[WDT_GEN] = nv_lock;
    end

    always_ff @(posedge clk) begin
        if (por_rst) gen_lock <= por_val;
        else         gen_lock <= gen_lock | (lock_set & ~NUM_GENS'(1));
    end

    assert_gen0_free_R4: assert property (@(posedge clk) disable iff (por_rst)
        !gen_lock[0]);

    assert_glock_sticky_R7: assert property (@(posedge clk) disable iff (por_rst)
        1'b1 |=> ((gen_lock & $past(gen_lock)) == $past(gen_lock)));

endmodule

// File: rtl/clkroute_regfile.sv
module clkroute_regfile
    import clkroute_pkg::*;
#(
    parameter int NUM_CH   = CH_COUNT,
    parameter int NUM_GENS = GEN_COUNT
) (
    input  logic                      clk,
    input  logic                      por_rst,
    input  logic                      usr_rst,
    input  logic                      nv_wdt_en,
    input  logic                      nv_wdt_lock,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata,
    output logic [NUM_CH*GEN_W-1:0]   gen_sel,
    output logic [NUM_CH-1:0]         clk_en,
    output logic [NUM_GENS-1:0]       gen_lock
);
    localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(NUM_CH);

    route_t              ent_q [NUM_CH];
    route_t              wr_tgt;
    route_t              rd_src;
    route_t              wr_route;
    logic [NUM_CH-1:0]   wr_sel;
    logic [NUM_GENS-1:0] lock_set;
    logic                wr_ok;
    logic [CH_W-1:0]     wr_ch;
    logic [CH_W-1:0]     cur_ch;

    always_comb begin
        wr_ch  = to_ctrl(wdata).ch;
        wr_tgt = '0;
        rd_src = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_ch == CH_W'(i))  wr_tgt = ent_q[i];
            if (cur_ch == CH_W'(i)) rd_src = ent_q[i];
        end
    end

    clkroute_wdec #(.NUM_CH(NUM_CH), .NUM_GENS(NUM_GENS)) u_wdec (
        .wr_en    (wr_en & ~usr_rst & ~por_rst),
        .wdata    (wdata),
        .tgt      (wr_tgt),
        .gen_lock (gen_lock),
        .wr_ok    (wr_ok),
        .wr_sel   (wr_sel),
        .wr_route (wr_route),
        .lock_set (lock_set)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkroute_entry #(.KIND(kind_of(i))) u_entry (
            .clk      (clk),
            .por_rst  (por_rst),
            .usr_rst  (usr_rst),
            .nv_en    (nv_wdt_en),
            .nv_lock  (nv_wdt_lock),
            .wr_sel   (wr_sel[i]),
            .wr_route (wr_route),
            .route_q  (ent_q[i])
        );
        assign gen_sel[i*GEN_W +: GEN_W] = ent_q[i].gen;
        assign clk_en[i]                 = ent_q[i].en;

        assert_lock_covers_gen_R4: assert property (@(posedge clk) disable iff (por_rst)
            (ent_q[i].lock && ent_q[i].gen != '0) |-> gen_lock[ent_q[i].gen]);
    end

    clkroute_glock #(.NUM_GENS(NUM_GENS)) u_glock (
        .clk      (clk),
        .por_rst  (por_rst),
        .nv_lock  (nv_wdt_lock),
        .lock_set (lock_set),
        .gen_lock (gen_lock)
    );

    always_ff @(posedge clk) begin
        if (por_rst || usr_rst) begin
            cur_ch <= '0;
            rdata  <= '0;
        end else begin
            if (wr_en) cur_ch <= wr_ch;
            if (rd_en) rdata  <= from_route(rd_src, cur_ch, cur_ch < CH_LIMIT);
        end
    end

    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (por_rst || usr_rst)
        !rd_en |=> $stable(rdata));

    assert_usr_blocks_write_R12: assert property (@(posedge clk) disable iff (por_rst)
        usr_rst |=> (cur_ch == '0 && rdata == '0));

    assert_no_accept_reserved_R3: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && wr_ch >= CH_LIMIT) |-> !wr_ok);

endmodule

// File: tb/clkroute_regfile_tb.sv
module clkroute_regfile_tb;
    localparam int NCH = 28;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        usr_rst = 1'b0;
    logic        nv_wdt_en = 1'b1;
    logic        nv_wdt_lock = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [NCH*3-1:0] gen_sel;
    logic [NCH-1:0]   clk_en;
    logic [7:0]       gen_lock;

    int errors = 0;
    int checks = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    int         m_gen [NCH];
    bit         m_en  [NCH];
    bit         m_lock[NCH];
    bit [7:0]   m_gl;
    int         m_ch;
    logic [15:0] m_rd;

    always #4 clk = ~clk;

    clkroute_regfile u_dut (
        .clk(clk), .por_rst(por_rst), .usr_rst(usr_rst),
        .nv_wdt_en(nv_wdt_en), .nv_wdt_lock(nv_wdt_lock),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .gen_sel(gen_sel), .clk_en(clk_en), .gen_lock(gen_lock)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int gsel(input int ch);
        return int'(gen_sel[ch*3 +: 3]);
    endfunction

    // behavioural reference model, updated on every edge
    always @(posedge clk) begin
        if (por_rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_gen[i] = 0; m_en[i] = 0; m_lock[i] = 0;
            end
            m_gen[1] = 2; m_en[1] = nv_wdt_en; m_lock[1] = nv_wdt_lock;
            m_gl = nv_wdt_lock ? 8'h04 : 8'h00;
            m_ch = 0; m_rd = '0;
        end else if (usr_rst) begin
            for (int i = 0; i < NCH; i++) begin
                if (i == 1) begin
                    if (!m_lock[i]) begin m_gen[i] = 2; m_en[i] = nv_wdt_en; end
                end else if (i == 2) begin
                    if (!m_lock[i] && !m_en[i]) m_gen[i] = 0;
                end else if (!m_lock[i]) begin
                    m_gen[i] = 0; m_en[i] = 0;
                end
            end
            m_ch = 0; m_rd = '0;
        end else begin
            if (rd_en) begin
                if (m_ch < NCH)
                    m_rd = {m_lock[m_ch], m_en[m_ch], 2'b00, 4'(m_gen[m_ch]), 2'b00, 6'(m_ch)};
                else
                    m_rd = {10'd0, 6'(m_ch)};
            end
            if (wr_en) begin
                int c, g;
                c = int'(wdata[5:0]);
                g = int'(wdata[11:8]);
                m_ch = c;
                if (c < NCH && g < 8 && !m_lock[c] && !m_gl[m_gen[c]]) begin
                    m_gen[c] = g; m_en[c] = wdata[14]; m_lock[c] = wdata[15];
                    if (wdata[15] && g != 0) m_gl[g] = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            for (int i = 0; i < NCH; i++) begin
                chk($sformatf("R11 gen_sel ch%0d", i), gsel(i), m_gen[i]);
                chk($sformatf("R11 clk_en ch%0d", i), 32'(clk_en[i]), 32'(m_en[i]));
            end
            chk("R4 gen_lock model", 32'(gen_lock), 32'(m_gl));
            chk("R1 rdata model", 32'(rdata), 32'(m_rd));
        end
    end

    task automatic wr(input logic [15:0] w);
        wr_en = 1'b1; wdata = w;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic por_pulse();
        por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0;
    endtask

    task automatic usr_pulse();
        usr_rst = 1'b1;
        @(negedge clk);
        usr_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        started = 1'b1;
        // R2 power-on state with watchdog enabled, unlocked
        chk("R2 wdt en", 32'(clk_en[1]), 1);
        chk("R2 wdt gen", gsel(1), 2);
        chk("R2 gen_lock", 32'(gen_lock), 0);
        chk("R2 rdata", 32'(rdata), 0);
        // R1 write then read back
        wr(16'h4305);
        chk("R11 ch5 gen", gsel(5), 3);
        rd();
        chk("R1 read ch5", 32'(rdata), 32'h4305);
        // R3 reserved channel and generator
        wr(16'h411C);
        rd();
        chk("R3 reserved ch read", 32'(rdata), 32'h001C);
        wr(16'h4906);
        chk("R3 reserved gen ignored", 32'(clk_en[6]), 0);
        rd();
        chk("R3 ptr follows write", 32'(rdata), 32'h0006);
        // R4 lock write
        wr(16'hC407);
        chk("R4 gen_lock set", 32'(gen_lock), 32'h10);
        rd();
        chk("R1 read locked ch7", 32'(rdata), 32'hC407);
        wr(16'h0107);
        chk("R5 locked ch7 gen", gsel(7), 4);
        chk("R5 locked ch7 en", 32'(clk_en[7]), 1);
        // R6 channel on a locked generator
        wr(16'h4408);
        chk("R6 first write accepted", gsel(8), 4);
        wr(16'h4508);
        chk("R6 frozen by gen lock", gsel(8), 4);
        // R4 generator 0 never locks
        wr(16'h8009);
        chk("R4 gen0 not locked", 32'(gen_lock), 32'h10);
        // user reset rules
        wr(16'h4102);
        wr(16'h4603);
        wr(16'h0501);
        chk("R10 wdt written", gsel(1), 5);
        usr_pulse();
        chk("R9 rtc enabled kept gen", gsel(2), 1);
        chk("R9 rtc enabled kept en", 32'(clk_en[2]), 1);
        chk("R8 plain cleared gen", gsel(3), 0);
        chk("R8 plain cleared en", 32'(clk_en[3]), 0);
        chk("R8 locked kept", gsel(7), 4);
        chk("R7 gen_lock kept", 32'(gen_lock), 32'h10);
        chk("R10 wdt reload gen", gsel(1), 2);
        chk("R10 wdt reload en", 32'(clk_en[1]), 1);
        rd();
        chk("R12 ptr cleared", 32'(rdata), 0);
        wr(16'h0302);
        usr_pulse();
        chk("R9 rtc disabled cleared", gsel(2), 0);
        // R12 write during user reset is lost
        usr_rst = 1'b1; wr_en = 1'b1; wdata = 16'h460A;
        @(negedge clk);
        usr_rst = 1'b0; wr_en = 1'b0; wdata = '0;
        chk("R12 write lost en", 32'(clk_en[10]), 0);
        chk("R12 write lost gen", gsel(10), 0);
        // power-on reset with watchdog locked
        nv_wdt_en = 1'b0; nv_wdt_lock = 1'b1;
        por_pulse();
        chk("R2 wdt locked gen_lock", 32'(gen_lock), 32'h04);
        chk("R2 wdt en from nv", 32'(clk_en[1]), 0);
        chk("R7 por clears ch7", gsel(7), 0);
        wr(16'h4107);
        chk("R7 ch7 writable after por", gsel(7), 1);
        wr(16'h4301);
        chk("R5 wdt locked gen", gsel(1), 2);
        rd();
        chk("R1 read locked wdt", 32'(rdata), 32'h8201);
        wr(16'h420C);
        wr(16'h450C);
        chk("R6 gen2 locked freezes ch12", gsel(12), 2);
        nv_wdt_en = 1'b1;
        usr_pulse();
        chk("R10 locked wdt unchanged", 32'(clk_en[1]), 0);
        chk("R7 gen_lock after usr", 32'(gen_lock), 32'h04);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule